// File: doc/BRIEF.md
# Double-Width Unsigned Divide with Remainder

This unit divides an unsigned dividend of twice the word width by a single-word divisor. It returns a single-word quotient and a single-word remainder. The dividend is built from two word operands, with the high word placed above the low word. The divisor is zero-extended to the dividend width. The unit serves two jobs in multi-word arithmetic: the quotient-estimate step of long division, and the digit-by-digit division loop. In that loop the remainder of one digit becomes the high word of the next.

The quotient always fits in one word, provided the high word is strictly below the divisor. No overflow flag and no condition output exist. The caller keeps that ordering itself, for example by starting the loop with a zero high word. Two cases break the ordering: a zero divisor, and a high word at or above the divisor. The unit catches both before any arithmetic starts. It then answers with an invalid indication, an all-ones quotient and a zero remainder.

The datapath is an iterative restoring divider. It retires one quotient bit per clock. A start/busy/done handshake controls it, and the operands are latched when a start is accepted.

Top module: `divrem_unit`

## Requirements
- R1: The dividend is `{hi_i, lo_i}` and the divisor is `div_i` zero-extended. When `hi_i < div_i`, `quot_o` and `rem_o` satisfy `{hi_i,lo_i} = quot_o*div_i + rem_o` with `rem_o < div_i`, and `invalid_o` is 0.
- R2: For a valid operation, `done_o` goes high for exactly one cycle. This happens XLEN+2 clock edges after the edge that accepts the start.
- R3: When `div_i` is zero, `done_o` pulses 2 edges after acceptance with `invalid_o` = 1, `quot_o` all ones and `rem_o` zero.
- R4: When `div_i` is nonzero and `hi_i >= div_i`, the result is the same invalid answer as in R3, with the same 2-edge latency.
- R5: `busy_o` rises on the edge that accepts a start. It stays high through the `done_o` cycle and is low on the following cycle.
- R6: A `start_i` asserted while `busy_o` is high is ignored. The running operation is not restarted, and its latency and result are unchanged.
- R7: Operands are sampled only on the accepting edge. Changes to `hi_i`, `lo_i` or `div_i` afterwards do not affect the result.
- R8: While `busy_o` and `start_i` are both low, `quot_o`, `rem_o` and `invalid_o` keep their last values.
- R9: During and right after reset, `busy_o`, `done_o` and `invalid_o` are 0, and `quot_o` and `rem_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request an operation; accepted when not busy |
| hi_i | input | XLEN | Upper word of the dividend |
| lo_i | input | XLEN | Lower word of the dividend |
| div_i | input | XLEN | Divisor |
| busy_o | output | 1 | Operation in progress, including the done cycle |
| done_o | output | 1 | One-cycle result-ready pulse |
| invalid_o | output | 1 | Divisor zero or high word not below divisor |
| quot_o | output | XLEN | Quotient |
| rem_o | output | XLEN | Remainder |

## Verification
The hardest case to reach is one where the quotient's top bit is set and every restoring step sits right at the subtract boundary. This needs the high word to be exactly one below the divisor, with a low word that makes each trial subtraction barely succeed or barely fail. With a 64-bit word such operands are rare under random stimulus. The bench therefore builds the unit with a 4-bit word and sweeps every high word, low word and divisor. This covers every boundary and every invalid-operand case with arithmetic reference values. Separate runs keep `start_i` high and churn the operands during busy, which exercises the ignore and capture rules.

// File: rtl/divrem_pkg.sv
package divrem_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } divrem_state_e;
endpackage

// File: rtl/divrem_precheck.sv
module divrem_precheck #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] div_i,
  output logic            div_zero_o,
  output logic            hi_ge_o,
  output logic            invalid_o
);
  always_comb begin
    div_zero_o = (div_i == '0);
    hi_ge_o    = (hi_i >= div_i);
    // hi >= 0 already covers zero divisor; kept explicit for clarity
    invalid_o  = div_zero_o | hi_ge_o;
  end
endmodule

// File: rtl/divrem_step.sv
module divrem_step #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0] rem_i,
  input  logic [XLEN-1:0] quo_i,
  input  logic [XLEN-1:0] div_i,
  output logic [XLEN-1:0] rem_o,
  output logic [XLEN-1:0] quo_o
);
  logic [XLEN:0]   trial;
  logic [XLEN-1:0] diff;
  logic            fits;

  always_comb begin
    trial = {rem_i, quo_i[XLEN-1]};
    fits  = (trial >= {1'b0, div_i});
    // true difference is below div_i, so the low XLEN bits are exact
    diff  = trial[XLEN-1:0] - div_i;
    rem_o = fits ? diff : trial[XLEN-1:0];
    quo_o = {quo_i[XLEN-2:0], fits};
  end
endmodule

// File: rtl/divrem_ctrl.sv
module divrem_ctrl
  import divrem_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic invalid_i,
  output logic accept_o,
  output logic load_inv_o,
  output logic step_o,
  output logic done_o,
  output logic busy_o
);
  localparam int CNT_W = $clog2(XLEN);
  localparam logic [CNT_W-1:0] LAST_CNT = CNT_W'(XLEN - 1);

  divrem_state_e state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    unique case (state_q)
      ST_IDLE:  if (start_i) state_d = ST_CHECK;
      ST_CHECK: begin
        cnt_d   = '0;
        state_d = invalid_i ? ST_DONE : ST_RUN;
      end
      ST_RUN: begin
        cnt_d = cnt_q + 1'b1;
        if (cnt_q == LAST_CNT) state_d = ST_DONE;
      end
      ST_DONE:  state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign accept_o   = (state_q == ST_IDLE) && start_i;
  assign load_inv_o = (state_q == ST_CHECK) && invalid_i;
  assign step_o     = (state_q == ST_RUN);
  assign done_o     = (state_q == ST_DONE);
  assign busy_o     = (state_q != ST_IDLE);
endmodule

// File: rtl/divrem_unit.sv
module divrem_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [XLEN-1:0] hi_i,
  input  logic [XLEN-1:0] lo_i,
  input  logic [XLEN-1:0] div_i,
  output logic            busy_o,
  output logic            done_o,
  output logic            invalid_o,
  output logic [XLEN-1:0] quot_o,
  output logic [XLEN-1:0] rem_o
);
  logic [XLEN-1:0] rem_q, quo_q, div_q;
  logic            inv_q;
  logic [XLEN-1:0] step_rem, step_quo;
  logic            pre_zero, pre_ge, pre_inv;
  logic            accept, load_inv, step;

  divrem_precheck #(.XLEN(XLEN)) u_precheck (
    .hi_i       (rem_q),
    .div_i      (div_q),
    .div_zero_o (pre_zero),
    .hi_ge_o    (pre_ge),
    .invalid_o  (pre_inv)
  );

  divrem_step #(.XLEN(XLEN)) u_step (
    .rem_i (rem_q),
    .quo_i (quo_q),
    .div_i (div_q),
    .rem_o (step_rem),
    .quo_o (step_quo)
  );

  divrem_ctrl #(.XLEN(XLEN)) u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start_i),
    .invalid_i  (pre_inv),
    .accept_o   (accept),
    .load_inv_o (load_inv),
    .step_o     (step),
    .done_o     (done_o),
    .busy_o     (busy_o)
  );

  // rem_q holds the high word until stepping starts; quo_q holds the low word
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q <= '0;
      quo_q <= '0;
      div_q <= '0;
      inv_q <= 1'b0;
    end else if (accept) begin
      rem_q <= hi_i;
      quo_q <= lo_i;
      div_q <= div_i;
      inv_q <= 1'b0;
    end else if (load_inv) begin
      rem_q <= '0;
      quo_q <= '1;
      inv_q <= 1'b1;
    end else if (step) begin
      rem_q <= step_rem;
      quo_q <= step_quo;
    end
  end

  assign quot_o    = quo_q;
  assign rem_o     = rem_q;
  assign invalid_o = inv_q;
endmodule

// File: rtl/divrem_unit_chk.sv
module divrem_unit_chk #(
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            start_i,
  input logic [XLEN-1:0] hi_i,
  input logic [XLEN-1:0] div_i,
  input logic            busy_o,
  input logic            done_o,
  input logic            invalid_o,
  input logic [XLEN-1:0] quot_o,
  input logic [XLEN-1:0] rem_o
);
  logic [XLEN-1:0] hi_cap, div_cap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hi_cap  <= '0;
      div_cap <= '0;
    end else if (start_i && !busy_o) begin
      hi_cap  <= hi_i;
      div_cap <= div_i;
    end
  end

  // R2
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R5
  accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_o) |=> (busy_o && !done_o));
  // R5
  done_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  // R6
  no_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> busy_o);
  // R3
  zero_div_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && div_cap == '0) |-> (invalid_o && quot_o == '1 && rem_o == '0));
  // R4
  hi_ge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hi_cap >= div_cap) |-> (invalid_o && quot_o == '1 && rem_o == '0));
  // R1
  rem_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && hi_cap < div_cap) |-> (!invalid_o && rem_o < div_cap));
  // R8
  hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && !start_i) |=> ($stable(quot_o) && $stable(rem_o) && $stable(invalid_o)));
endmodule

bind divrem_unit divrem_unit_chk #(.XLEN(XLEN)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .start_i   (start_i),
  .hi_i      (hi_i),
  .div_i     (div_i),
  .busy_o    (busy_o),
  .done_o    (done_o),
  .invalid_o (invalid_o),
  .quot_o    (quot_o),
  .rem_o     (rem_o)
);

// File: tb/divrem_unit_bench.sv
module divrem_unit_bench;
  localparam int XLEN = 4;
  localparam int VMAX = 1 << XLEN;

  logic            clk_i = 1'b0;
  logic            rst_ni = 1'b0;
  logic            start_i = 1'b0;
  logic [XLEN-1:0] hi_i = '0, lo_i = '0, div_i = '0;
  logic            busy_o, done_o, invalid_o;
  logic [XLEN-1:0] quot_o, rem_o;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit finished = 0;

  divrem_unit #(.XLEN(XLEN)) u_divrem_unit (
    .clk_i(clk_i), .rst_ni(rst_ni), .start_i(start_i),
    .hi_i(hi_i), .lo_i(lo_i), .div_i(div_i),
    .busy_o(busy_o), .done_o(done_o), .invalid_o(invalid_o),
    .quot_o(quot_o), .rem_o(rem_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000 && !finished) begin
      finished = 1;
      failures++;
      checks++;
      $display("FAIL watchdog act=%0d exp<=150000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic run_op(input int hi, input int lo, input int d, input bit disturb);
    int lat, dvd, eq, er, elat, k;
    bit einv;
    string tag;
    dvd  = hi * VMAX + lo;
    einv = (d == 0) || (hi >= d);
    eq   = einv ? VMAX - 1 : dvd / d;
    er   = einv ? 0 : dvd % d;
    elat = einv ? 2 : XLEN + 2;
    tag  = disturb ? "R6" : (d == 0 ? "R3" : (einv ? "R4" : "R1"));
    hi_i = XLEN'(hi); lo_i = XLEN'(lo); div_i = XLEN'(d);
    start_i = 1'b1;
    @(negedge clk_i);
    lat = 1;
    start_i = disturb;
    chk(busy_o && !done_o, "R5", "busy after accept", {busy_o, done_o}, 2'b10);
    k = 0;
    while (!done_o && lat < 64) begin
      if (disturb) begin
        // R7: operands churn after capture
        k++;
        hi_i = XLEN'(hi + 5 * k); lo_i = XLEN'(lo + 3 * k); div_i = XLEN'(d + k);
      end
      @(negedge clk_i);
      lat++;
    end
    start_i = 1'b0;
    chk(lat == elat, einv ? tag : (disturb ? "R6" : "R2"), "latency", lat, elat);
    chk(quot_o == XLEN'(eq), disturb ? "R7" : tag, "quotient", quot_o, eq);
    chk(rem_o == XLEN'(er), disturb ? "R7" : tag, "remainder", rem_o, er);
    chk(invalid_o == einv, tag, "invalid", invalid_o, einv);
    @(negedge clk_i);
    chk(!busy_o && !done_o, "R5", "idle after done (R2 one-cycle)", {busy_o, done_o}, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(!busy_o && !done_o && !invalid_o && quot_o == 0 && rem_o == 0,
        "R9", "in reset", {busy_o, done_o, invalid_o, quot_o, rem_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(!busy_o && !done_o && !invalid_o && quot_o == 0 && rem_o == 0,
        "R9", "after reset", {busy_o, done_o, invalid_o, quot_o, rem_o}, 0);

    // R1 R3 R4: exhaustive sweep over the small word
    for (int d = 0; d < VMAX; d++)
      for (int h = 0; h < VMAX; h++)
        for (int l = 0; l < VMAX; l++)
          run_op(h, l, d, 1'b0);

    // R6 R7: start held high with churning operands while busy
    run_op(6, 9, 7, 1'b1);
    run_op(14, 15, 15, 1'b1);
    run_op(0, 1, 1, 1'b1);
    run_op(3, 2, 0, 1'b1);

    // R8: outputs hold while idle and start low
    run_op(5, 11, 9, 1'b0);
    for (int i = 0; i < 6; i++) begin
      hi_i = XLEN'(i); lo_i = XLEN'(i * 3); div_i = XLEN'(i + 1);
      @(negedge clk_i);
      chk(quot_o == XLEN'((5 * VMAX + 11) / 9) && rem_o == XLEN'((5 * VMAX + 11) % 9)
          && !invalid_o && !busy_o,
          "R8", "hold while idle", {invalid_o, quot_o, rem_o},
          {1'b0, 4'((5 * VMAX + 11) / 9), 4'((5 * VMAX + 11) % 9)});
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule